// File: doc/BRIEF.md
# Ternary Search Table with Learn

This block holds a small table of 72-bit ternary entries. Each entry is a data word and a mask word stored side by side. A host reaches it through an 11-bit command word that a valid strobe qualifies. The two low bits of the command pick the operation, and the upper nine bits carry its parameter. For a read or a write, the low bits of that parameter are the entry address. A read returns both words of one entry, and a write stores both words of one entry.

A search compares a 72-bit key against every occupied entry at once, under each entry's own mask. It reports a hit flag and the index of the matching entry nearest address 0. A learn command stores the key, with its mask, into the lowest free entry, so the host can grow the table without tracking free slots.

Bit 0 of every data word is the occupancy marker: 0 means free and 1 means in use. That bit is not part of the comparison. It decides whether an entry may match at all, which slot a learn fills, and whether the table reports itself full.

A Moore controller registers the last accepted command into one of six states:
- `ST_IDLE`: no command.
- `ST_READ`: read data is presented.
- `ST_WRITE`: a write was taken.
- `ST_SEARCH`: a search result is presented.
- `ST_LEARN`: a learn was stored.
- `ST_REFUSE`: a learn arrived while the table was full.

On every clock edge the next state is chosen from the command:
- If `cmd_valid` is low, the next state is `ST_IDLE`.
- Opcode 00 goes to `ST_READ`.
- Opcode 01 goes to `ST_WRITE`.
- Opcode 10 goes to `ST_SEARCH`.
- Opcode 11 goes to `ST_LEARN`, or to `ST_REFUSE` if `full` is high.

Any state can reach any other state in one cycle. A new command can therefore be given every cycle.

Top module: `tern_table`

## Requirements
- R1: While `rst_n` is low, every entry is cleared, including its occupancy bit. After reset `full` is 0, all strobes are 0, and any search misses.
- R2: A cycle with `cmd_valid` = 0 raises no strobe on the next cycle and changes no entry.
- R3: Opcode 01 stores `key_data` and `key_mask` at the address in `cmd[2+AW-1:2]`. Opcode 00 returns that entry's data and mask on `rd_data`/`rd_mask`, with `rd_valid` high for the one cycle after the command.
- R4: Opcode 10 raises `res_valid` for the one cycle after the command. `res_hit` is 1 when some occupied entry has `(key ^ data) & mask` equal to zero over bits 71..1.
- R5: A mask bit of 0 makes that key bit a don't-care for that entry.
- R6: When several entries match, `res_index` is the lowest matching address.
- R7: An entry whose data bit 0 is 0 never matches, whatever its other bits hold.
- R8: Opcode 11, when `full` is 0, writes `key_data` with bit 0 forced to 1, together with `key_mask`, into the lowest-address entry whose bit 0 is 0.
- R9: `full` is 1 exactly when bit 0 of every entry is 1.
- R10: Opcode 11 while `full` is 1 changes no entry and pulses `learn_fail` for one cycle.
- R11: At most one of `rd_valid`, `res_valid` and `learn_fail` is high in any cycle. A write or a successful learn raises none of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Qualifies `cmd` |
| cmd | input | 11 | [1:0] opcode, [10:2] parameter (entry address) |
| key_data | input | 72 | Write data, search key or learn key |
| key_mask | input | 72 | Write mask or learn mask (1 = compare) |
| rd_valid | output | 1 | Read data valid strobe |
| rd_data | output | 72 | Data word of the read entry |
| rd_mask | output | 72 | Mask word of the read entry |
| res_valid | output | 1 | Search result strobe |
| res_hit | output | 1 | Search found a match |
| res_index | output | 4 | Winning entry address, meaningless when `res_hit` is 0 |
| learn_fail | output | 1 | Learn refused because the table was full |
| full | output | 1 | Every entry is occupied |

## Verification
Directed searches separate the cases that a plain equality compare would confuse:
- An exact key hits.
- A key differing in one masked-in bit misses.
- The same key hits once another entry masks that bit out.
- An identical entry at a lower address takes over the result.
- A matching entry with its occupancy bit clear is passed over.

Learn is driven until the table fills, checking which slot each learn lands in, the cycle in which `full` rises, and that one more learn is refused without touching storage. Random writes, with sparse mask holes and occasional cleared occupancy bits, are mixed with searches on near-copies of stored words. Each result is compared against a bench model. This tells priority errors apart from compare errors.

// File: rtl/tern_pkg.sv
package tern_pkg;

    typedef enum logic [1:0] {
        OP_READ  = 2'b00,
        OP_WRITE = 2'b01,
        OP_FIND  = 2'b10,
        OP_LEARN = 2'b11
    } op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_WRITE,
        ST_SEARCH,
        ST_LEARN,
        ST_REFUSE
    } state_e;

endpackage

// File: rtl/tern_store.sv
module tern_store #(
    parameter int W     = 72,
    parameter int DEPTH = 16,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       we,
    input  logic [AW-1:0]              waddr,
    input  logic [W-1:0]               wdata,
    input  logic [W-1:0]               wmask,
    output logic [DEPTH-1:0][W-1:0]    data_q,
    output logic [DEPTH-1:0][W-1:0]    mask_q,
    output logic [DEPTH-1:0]           occ
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            mask_q <= '0;
        end else if (we) begin
            data_q[waddr] <= wdata;
            mask_q[waddr] <= wmask;
        end
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_occ
        assign occ[i] = data_q[i][0];
    end

    // A write or learn lands in the addressed slot on the next cycle
    assert_write_lands_R3: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (data_q[$past(waddr)] == $past(wdata)) && (mask_q[$past(waddr)] == $past(wmask)));

endmodule

// File: rtl/tern_match.sv
module tern_match #(
    parameter int W     = 72,
    parameter int DEPTH = 16
) (
    input  logic [W-1:0]            key,
    input  logic [DEPTH-1:0][W-1:0] data_q,
    input  logic [DEPTH-1:0][W-1:0] mask_q,
    output logic [DEPTH-1:0]        hits
);

    localparam int CW = W - 1;

    for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
        logic [CW-1:0] diff;
        assign diff    = (key[W-1:1] ^ data_q[i][W-1:1]) & mask_q[i][W-1:1];
        assign hits[i] = data_q[i][0] && (diff == '0);
    end

endmodule

// File: rtl/tern_prio.sv
module tern_prio #(
    parameter int N  = 16,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    output logic          found,
    output logic [IW-1:0] idx
);

    always_comb begin
        found = |req;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IW'(i);
        end
    end

    // Winner is requesting and nothing below it requests
    always_comb begin
        if (found) begin
            assert_lowest_R6: assert (req[idx] && ((req & ((N'(1) << idx) - N'(1))) == '0));
        end
    end

endmodule

// File: rtl/tern_table.sv
module tern_table
    import tern_pkg::*;
#(
    parameter int W     = 72,
    parameter int DEPTH = 16,
    parameter int CMD_W = 11,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [CMD_W-1:0] cmd,
    input  logic [W-1:0]     key_data,
    input  logic [W-1:0]     key_mask,
    output logic             rd_valid,
    output logic [W-1:0]     rd_data,
    output logic [W-1:0]     rd_mask,
    output logic             res_valid,
    output logic             res_hit,
    output logic [AW-1:0]    res_index,
    output logic             learn_fail,
    output logic             full
);

    state_e state_q, state_nx;
    op_e    op;
    logic [AW-1:0] cmd_addr;

    logic [DEPTH-1:0][W-1:0] data_q, mask_q;
    logic [DEPTH-1:0]        occ, hits;
    logic                    any_hit, any_free;
    logic [AW-1:0]           hit_idx, free_idx;

    logic          st_we;
    logic [AW-1:0] st_addr;
    logic [W-1:0]  st_data;

    assign op       = op_e'(cmd[1:0]);
    assign cmd_addr = cmd[2 +: AW];
    assign full     = &occ;

    tern_store #(.W(W), .DEPTH(DEPTH), .AW(AW)) u_store (
        .clk(clk), .rst_n(rst_n), .we(st_we), .waddr(st_addr),
        .wdata(st_data), .wmask(key_mask),
        .data_q(data_q), .mask_q(mask_q), .occ(occ)
    );

    tern_match #(.W(W), .DEPTH(DEPTH)) u_match (
        .key(key_data), .data_q(data_q), .mask_q(mask_q), .hits(hits)
    );

    tern_prio #(.N(DEPTH), .IW(AW)) u_hit_enc (
        .req(hits), .found(any_hit), .idx(hit_idx)
    );

    tern_prio #(.N(DEPTH), .IW(AW)) u_free_enc (
        .req(~occ), .found(any_free), .idx(free_idx)
    );

    // Next-state decode from the qualified command
    always_comb begin
        state_nx = ST_IDLE;
        if (cmd_valid) begin
            unique case (op)
                OP_READ:  state_nx = ST_READ;
                OP_WRITE: state_nx = ST_WRITE;
                OP_FIND:  state_nx = ST_SEARCH;
                OP_LEARN: state_nx = full ? ST_REFUSE : ST_LEARN;
                default:  state_nx = ST_IDLE;
            endcase
        end
    end

    // Storage write port: register write or a granted learn
    always_comb begin
        st_we   = 1'b0;
        st_addr = cmd_addr;
        st_data = key_data;
        if (state_nx == ST_WRITE) begin
            st_we = 1'b1;
        end else if (state_nx == ST_LEARN) begin
            st_we   = any_free;
            st_addr = free_idx;
            st_data = {key_data[W-1:1], 1'b1};
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_nx;
    end

    // Result payload registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data   <= '0;
            rd_mask   <= '0;
            res_hit   <= 1'b0;
            res_index <= '0;
        end else begin
            if (state_nx == ST_READ) begin
                rd_data <= data_q[cmd_addr];
                rd_mask <= mask_q[cmd_addr];
            end
            if (state_nx == ST_SEARCH) begin
                res_hit   <= any_hit;
                res_index <= hit_idx;
            end
        end
    end

    // Moore strobes
    always_comb begin
        rd_valid   = 1'b0;
        res_valid  = 1'b0;
        learn_fail = 1'b0;
        unique case (state_q)
            ST_READ:   rd_valid   = 1'b1;
            ST_SEARCH: res_valid  = 1'b1;
            ST_REFUSE: learn_fail = 1'b1;
            ST_IDLE, ST_WRITE, ST_LEARN: ;
            default: ;
        endcase
    end

    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |=> !(rd_valid || res_valid || learn_fail));

    assert_read_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd[1:0] == 2'b00) |=> rd_valid);

    assert_search_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd[1:0] == 2'b10) |=> res_valid);

    assert_refuse_keeps_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd[1:0] == 2'b11 && full) |=> (learn_fail && full && $stable(occ)));

    assert_learn_marks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd[1:0] == 2'b11 && !full) |=> ($countones(occ) == $countones($past(occ)) + 1));

    assert_one_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rd_valid, res_valid, learn_fail}));

endmodule

// File: tb/tb_tern_table.sv
`timescale 1ns/1ps
module tb_tern_table;

    localparam int W = 72, DEPTH = 16, AW = 4;

    logic clk = 1'b0, rst_n = 1'b0, cmd_valid = 1'b0;
    logic [10:0] cmd = '0;
    logic [W-1:0] key_data = '0, key_mask = '0;
    logic rd_valid, res_valid, res_hit, learn_fail, full;
    logic [W-1:0] rd_data, rd_mask;
    logic [AW-1:0] res_index;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    logic [W-1:0] m_data [DEPTH];
    logic [W-1:0] m_mask [DEPTH];

    always #2.5 clk = ~clk;

    tern_table dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd(cmd),
        .key_data(key_data), .key_mask(key_mask), .rd_valid(rd_valid),
        .rd_data(rd_data), .rd_mask(rd_mask), .res_valid(res_valid),
        .res_hit(res_hit), .res_index(res_index), .learn_fail(learn_fail),
        .full(full)
    );

    task automatic chk(input bit ok, input string req, input logic [143:0] act, input logic [143:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic bit m_full();
        for (int i = 0; i < DEPTH; i++) if (!m_data[i][0]) return 0;
        return 1;
    endfunction

    function automatic int m_search(input logic [W-1:0] k);
        for (int i = 0; i < DEPTH; i++)
            if (m_data[i][0] && (((k ^ m_data[i]) & m_mask[i]) >> 1) == '0) return i;
        return -1;
    endfunction

    function automatic int m_free();
        for (int i = 0; i < DEPTH; i++) if (!m_data[i][0]) return i;
        return -1;
    endfunction

    function automatic logic [W-1:0] rnd72();
        logic [95:0] t;
        t = {$urandom, $urandom, $urandom};
        return t[W-1:0];
    endfunction

    task automatic issue(input logic [1:0] op, input int addr, input logic [W-1:0] d, input logic [W-1:0] m);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd = {9'(addr), op};
        key_data = d;
        key_mask = m;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic do_write(input int a, input logic [W-1:0] d, input logic [W-1:0] m);
        issue(2'b01, a, d, m);
        chk(!rd_valid && !res_valid && !learn_fail, "R11 write strobes", {rd_valid, res_valid, learn_fail}, 0);
        m_data[a] = d;
        m_mask[a] = m;
        chk(full == m_full(), "R9 full after write", full, m_full());
    endtask

    task automatic do_read(input int a);
        issue(2'b00, a, '0, '0);
        chk(rd_valid && !res_valid && !learn_fail, "R11 read strobes", {rd_valid, res_valid, learn_fail}, 3'b100);
        chk(rd_data == m_data[a] && rd_mask == m_mask[a], "R3 read back",
            {rd_data, rd_mask}, {m_data[a], m_mask[a]});
    endtask

    task automatic do_search(input logic [W-1:0] k, input string req);
        int e;
        e = m_search(k);
        issue(2'b10, 0, k, '0);
        chk(res_valid && !rd_valid && !learn_fail, "R11 search strobes", {rd_valid, res_valid, learn_fail}, 3'b010);
        chk(res_hit == (e >= 0), req, res_hit, (e >= 0));
        if (e >= 0) chk(res_index == AW'(e), req, res_index, e);
    endtask

    task automatic do_learn(input logic [W-1:0] k, input logic [W-1:0] m);
        int slot;
        bit was_full;
        was_full = m_full();
        slot = m_free();
        issue(2'b11, 0, k, m);
        if (was_full) begin
            chk(learn_fail && !rd_valid && !res_valid, "R10 learn refused", {rd_valid, res_valid, learn_fail}, 3'b001);
        end else begin
            chk(!learn_fail && !rd_valid && !res_valid, "R11 learn strobes", {rd_valid, res_valid, learn_fail}, 0);
            m_data[slot] = {k[W-1:1], 1'b1};
            m_mask[slot] = m;
        end
        chk(full == m_full(), "R9 full after learn", full, m_full());
    endtask

    task automatic idle_check();
        @(negedge clk);
        key_data = rnd72();
        cmd = 11'h7FF;
        @(negedge clk);
        chk(!rd_valid && !res_valid && !learn_fail, "R2 idle quiet", {rd_valid, res_valid, learn_fail}, 0);
        chk(full == m_full(), "R2 idle full", full, m_full());
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] d5;
        logic [W-1:0] ones;
        void'($urandom(32'd20240611));
        ones = '1;
        for (int i = 0; i < DEPTH; i++) begin
            m_data[i] = '0;
            m_mask[i] = '0;
        end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(!full && !rd_valid && !res_valid && !learn_fail, "R1 reset outputs",
            {full, rd_valid, res_valid, learn_fail}, 0);
        do_search('0, "R1 empty table misses");
        do_read(9);

        // R3 write/read, R4 exact and near miss
        d5 = {rnd72()} | 72'h1;
        do_write(5, d5, ones);
        do_read(5);
        do_search(d5, "R4 exact hit");
        do_search(d5 ^ (72'h1 << 40), "R4 one-bit miss");
        // R5 masked bit
        do_write(6, d5, ones & ~(72'h1 << 40));
        do_search(d5 ^ (72'h1 << 40), "R5 masked bit ignored");
        // R6 lowest wins
        do_write(2, d5, ones);
        do_search(d5, "R6 lowest index");
        // R7 empty entry passed over
        do_write(1, d5 & ~72'h1, ones);
        do_search(d5, "R7 empty never matches");
        do_search(d5 & ~72'h1, "R7 key bit0 not compared");

        // R8 learn into lowest free slot, fill the table
        do_learn(72'hABCD_0000_1234_5678_9A, ones);
        do_read(0);
        do_search(72'hABCD_0000_1234_5678_9A, "R8 learned entry hits");
        for (int n = 0; n < 12; n++) begin
            do_learn(rnd72(), ones);
            chk(full == (n == 11), "R9 full timing", full, (n == 11));
        end
        do_read(1);
        do_learn(rnd72(), ones);
        do_read(15);
        idle_check();
        do_write(3, rnd72() & ~72'h1, ones);
        chk(!full, "R9 full drops", full, 0);
        do_learn(d5, ones);
        do_read(3);

        // Random mix against the model
        for (int it = 0; it < 600; it++) begin
            int sel;
            sel = int'($urandom % 16);
            if (sel < 5) begin
                logic [W-1:0] d;
                d = rnd72();
                d[0] = ($urandom % 4) != 0;
                do_write(int'($urandom % DEPTH), d, ~(rnd72() & rnd72() & rnd72()));
            end else if (sel < 12) begin
                logic [W-1:0] k;
                k = m_data[$urandom % DEPTH];
                if ($urandom % 2) k = k ^ (72'h1 << ($urandom % W));
                do_search(k, "R4 random search");
            end else if (sel < 14) begin
                do_read(int'($urandom % DEPTH));
            end else if (sel < 15) begin
                do_learn(rnd72(), ~(rnd72() & rnd72()));
            end else begin
                idle_check();
            end
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule